// File: doc/BRIEF.md
# Tick-Driven Multi-Channel Down-Counter

This block holds a set of independent down-counting channels that advance on a slow tick input. Software programs each channel through a small word-addressed register bus. A preload value sets the starting count. A control word selects whether the channel stops at zero (one-shot) or reloads itself and keeps running (periodic). The tick input may come from another clock domain, so it is resynchronised, and each of its rising edges becomes one single-cycle count step.

When a channel's count reaches zero it sets a sticky flag. Software clears a flag by writing a 1 to its bit. The flags that a mask register allows are ORed into one registered interrupt line.

Address layout (word address `reg_addr[3:0]`):
- `reg_addr[3:2]` selects the region.
- `reg_addr[1:0]` selects the channel where a region is per-channel.
- Region 0: a write sets the preload and a read returns the live count.
- Region 1: control, with bit 0 as enable and bit 1 as periodic mode.
- Region 2: flag status.
- Region 3: interrupt mask.

Read data appears on `reg_rdata` on the clock edge that samples `reg_rd`.

Top module: `tick_timer_bank`

## Requirements
- R1: After synchronous reset, every live count, control word, flag and mask bit reads 0, and `irq` is 0.
- R2: A write to region 0 of channel n stores the preload without changing the live count. A read of region 0 of channel n returns the live count.
- R3: A control write that turns enable (bit 0) from 0 to 1 copies the preload into the live count. A control write while enable is already 1 leaves the count untouched.
- R4: Each rising edge of `tick_in` lowers the count of every enabled channel by exactly one, no matter how long `tick_in` stays high.
- R5: In one-shot mode (control bit 1 = 0), the tick that takes the count from 1 to 0 sets the channel's flag. The following tick holds the count at 0, clears enable bit 0, and sets no new flag.
- R6: In periodic mode (control bit 1 = 1), the tick after the count reaches 0 reloads the preload and counting continues. The flag is set again each time the count reaches 0.
- R7: In periodic mode with a preload of 0, every tick sets the flag and the count stays 0, never wrapping to all ones.
- R8: A channel with enable 0 ignores ticks, and its count holds.
- R9: Flags (region 2, bit n for channel n) stay set until a write with a 1 in that bit clears them. Writing 0 bits leaves the flags as they are.
- R10: `irq` is 1 one cycle after any flag whose mask bit (region 3, bit n) is 1 is set, and 0 otherwise.
- R11: A tick or register access aimed at one channel leaves the count of every other disabled channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous count tick; rising edges count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address: region in [3:2], channel in [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered masked OR of the sticky flags |

## Verification
A live count that drifts shows up on the very next read of region 0. A missed or doubled tick step makes the count differ from the tick total within one tick period. A wrong terminal-count decision has visible effects. It sets a flag at the wrong count, which region 2 shows one tick after the fault. It also leaves enable set or cleared wrongly, which region 1 shows on the tick after zero. A flag or mask error reaches `irq` one cycle later.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    RG_COUNT  = 2'd0,
    RG_CTRL   = 2'd1,
    RG_STATUS = 2'd2,
    RG_MASK   = 2'd3
  } region_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic tick_step
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_async};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick_step = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/countdown_channel.sv
module countdown_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_val,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic             ctrl_periodic,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             periodic,
  output logic             term_hit
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             per_q;
  logic             start;
  logic             step;
  logic             at_zero;

  assign start   = ctrl_we & ctrl_en & ~en_q;
  assign step    = ~ctrl_we & en_q & tick;
  assign at_zero = (cnt_q == '0);

  // Flag event: count falls from 1 to 0, or a periodic reload of a zero preload.
  assign term_hit = step & ((cnt_q == CNT_W'(1)) | (at_zero & per_q & (pre_q == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      per_q <= 1'b0;
    end else begin
      if (pre_we) pre_q <= pre_val;
      if (ctrl_we) begin
        en_q  <= ctrl_en;
        per_q <= ctrl_periodic;
        if (start) cnt_q <= pre_q;
      end else if (step) begin
        if (!at_zero)   cnt_q <= cnt_q - CNT_W'(1);
        else if (per_q) cnt_q <= pre_q;
        else            en_q  <= 1'b0;
      end
    end
  end

  assign count    = cnt_q;
  assign enabled  = en_q;
  assign periodic = per_q;
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] mask_val,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (mask_we) mask <= mask_val;
      irq <= |(flags & mask);
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  import tick_timer_pkg::*;

  logic                          tick_step;
  region_e                       region;
  logic [CH_W-1:0]               ch_idx;
  logic [NUM_CH-1:0]             pre_we;
  logic [NUM_CH-1:0]             ctrl_we;
  logic [NUM_CH-1:0]             clr_vec;
  logic [NUM_CH-1:0]             hit_vec;
  logic [NUM_CH-1:0]             en_vec;
  logic [NUM_CH-1:0]             mode_vec;
  logic [NUM_CH-1:0]             flags;
  logic [NUM_CH-1:0]             mask;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec;
  logic                          mask_we;
  logic [CNT_W-1:0]              rdata_n;

  assign region = region_e'(reg_addr[ADDR_W-1 -: 2]);
  assign ch_idx = reg_addr[CH_W-1:0];

  tick_edge_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .tick_async(tick_in), .tick_step(tick_step)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign pre_we[g]  = reg_wr & (region == RG_COUNT) & (ch_idx == CH_W'(g));
    assign ctrl_we[g] = reg_wr & (region == RG_CTRL)  & (ch_idx == CH_W'(g));

    countdown_channel #(.CNT_W(CNT_W)) i_chan (
      .clk(clk), .rst(rst), .tick(tick_step),
      .pre_we(pre_we[g]), .pre_val(reg_wdata),
      .ctrl_we(ctrl_we[g]),
      .ctrl_en(reg_wdata[CTRL_EN_BIT]),
      .ctrl_periodic(reg_wdata[CTRL_MODE_BIT]),
      .count(cnt_vec[g]), .enabled(en_vec[g]), .periodic(mode_vec[g]),
      .term_hit(hit_vec[g])
    );
  end

  assign clr_vec = (reg_wr && region == RG_STATUS) ? reg_wdata[NUM_CH-1:0] : '0;
  assign mask_we = reg_wr & (region == RG_MASK);

  irq_combiner #(.NUM_CH(NUM_CH)) i_irq (
    .clk(clk), .rst(rst), .set_vec(hit_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_val(reg_wdata[NUM_CH-1:0]),
    .flags(flags), .mask(mask), .irq(irq)
  );

  always_comb begin
    rdata_n = '0;
    unique case (region)
      RG_COUNT: if (32'(ch_idx) < NUM_CH) rdata_n = cnt_vec[ch_idx];
      RG_CTRL: if (32'(ch_idx) < NUM_CH) begin
        rdata_n[CTRL_EN_BIT]   = en_vec[ch_idx];
        rdata_n[CTRL_MODE_BIT] = mode_vec[ch_idx];
      end
      RG_STATUS: rdata_n[NUM_CH-1:0] = flags;
      RG_MASK:   rdata_n[NUM_CH-1:0] = mask;
      default:   rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_n;
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tick,
  input logic [NUM_CH-1:0]            ctrl_we,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            en,
  input logic [NUM_CH-1:0]            mode,
  input logic [NUM_CH-1:0]            flags,
  input logic [NUM_CH-1:0]            mask,
  input logic [NUM_CH-1:0]            clr,
  input logic                         irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && en[g] && !ctrl_we[g] && cnt[g] != '0) |=> cnt[g] == $past(cnt[g]) - CNT_W'(1));
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && en[g] && !mode[g] && !ctrl_we[g] && cnt[g] == '0) |=> (!en[g] && cnt[g] == '0));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!en[g] && !ctrl_we[g]) |=> $stable(cnt[g]));
    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (flags[g] && !clr[g]) |=> flags[g]);
  end
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(flags & mask)));
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .tick(tick_step), .ctrl_we(ctrl_we), .cnt(cnt_vec),
  .en(en_vec), .mode(mode_vec), .flags(flags), .mask(mask), .clr(clr_vec), .irq(irq)
);

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  tick_timer_bank i_tick_timer_bank (
    .clk(clk), .rst(rst), .tick_in(tick_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick(input int hold);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (hold) @(negedge clk);
    tick_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [3:0] ad(input int region, input int ch);
    return 4'((region << 2) | ch);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(ad(0, c), v); check("R1 count", v, 0);
      rd(ad(1, c), v); check("R1 ctrl", v, 0);
    end
    rd(ad(2, 0), v); check("R1 flags", v, 0);
    rd(ad(3, 0), v); check("R1 mask", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // One-shot sweep on every channel
    for (int c = 0; c < 4; c++) begin
      int p = 3 + c;
      wr(ad(0, c), 32'(p));
      rd(ad(0, c), v); check("R2 preload keeps count", v, 0);
      wr(ad(1, c), 32'h1);
      rd(ad(0, c), v); check("R3 enable loads", v, 32'(p));
      for (int k = 1; k <= p; k++) begin
        tick(1 + (k % 4));
        rd(ad(0, c), v); check("R4 count step", v, 32'(p - k));
        rd(ad(2, 0), v);
        check("R5 flag at zero", v, (k == p) ? (32'h1 << c) : 32'h0);
      end
      rd(ad(1, c), v); check("R5 enable before stop", v, 32'h1);
      tick(2);
      rd(ad(0, c), v); check("R5 hold zero", v, 0);
      rd(ad(1, c), v); check("R5 enable cleared", v, 0);
      wr(ad(2, 0), 32'h0);
      rd(ad(2, 0), v); check("R9 zero write keeps", v, 32'h1 << c);
      wr(ad(2, 0), 32'h1 << c);
      rd(ad(2, 0), v); check("R9 w1c", v, 0);
      for (int o = 0; o < 4; o++)
        if (o != c) begin rd(ad(0, o), v); check("R11 other idle", v, 0); end
    end

    // Periodic mode on channel 1
    wr(ad(0, 1), 32'd2);
    wr(ad(1, 1), 32'h3);
    rd(ad(0, 1), v); check("R3 periodic load", v, 2);
    tick(1); tick(1);
    rd(ad(0, 1), v); check("R6 reach zero", v, 0);
    rd(ad(2, 0), v); check("R6 flag", v, 32'h2);
    wr(ad(2, 0), 32'h2);
    tick(1);
    rd(ad(0, 1), v); check("R6 reload", v, 2);
    rd(ad(2, 0), v); check("R6 no flag on reload", v, 0);
    rd(ad(1, 1), v); check("R6 still enabled", v, 32'h3);
    tick(1); tick(1);
    rd(ad(2, 0), v); check("R6 flag again", v, 32'h2);
    wr(ad(2, 0), 32'h2);
    wr(ad(1, 1), 32'h0);

    // Channel 2: disable hold and enable-rise reload
    wr(ad(0, 2), 32'd5);
    wr(ad(1, 2), 32'h3);
    tick(1);
    wr(ad(1, 2), 32'h2);
    tick(1); tick(3); tick(1);
    rd(ad(0, 2), v); check("R8 disabled holds", v, 4);
    rd(ad(0, 1), v); check("R11 ch1 untouched", v, 0);
    wr(ad(1, 2), 32'h3);
    rd(ad(0, 2), v); check("R3 rise reloads", v, 5);
    tick(1);
    wr(ad(0, 2), 32'd9);
    rd(ad(0, 2), v); check("R2 preload while running", v, 4);
    wr(ad(1, 2), 32'h3);
    rd(ad(0, 2), v); check("R3 no reload when on", v, 4);
    wr(ad(1, 2), 32'h0);

    // Channel 3: periodic with zero preload
    wr(ad(0, 3), 32'd0);
    wr(ad(1, 3), 32'h3);
    for (int k = 0; k < 3; k++) begin
      tick(1);
      rd(ad(0, 3), v); check("R7 stays zero", v, 0);
      rd(ad(2, 0), v); check("R7 flag each tick", v, 32'h8);
      wr(ad(2, 0), 32'h8);
    end

    // Interrupt masking
    tick(1);
    repeat (2) @(negedge clk);
    check("R10 masked off", {31'b0, irq}, 0);
    wr(ad(3, 0), 32'h8);
    repeat (2) @(negedge clk);
    check("R10 irq high", {31'b0, irq}, 1);
    wr(ad(3, 0), 32'h7);
    repeat (2) @(negedge clk);
    check("R10 other mask bits", {31'b0, irq}, 0);
    wr(ad(3, 0), 32'h8);
    wr(ad(2, 0), 32'h8);
    repeat (2) @(negedge clk);
    check("R10 cleared", {31'b0, irq}, 0);
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule